// File: doc/BRIEF.md
# Serial Register Loader with Channel Power Control

This block receives programming words over a three-line serial port: a serial clock, a data line and a load strobe. It assembles a 22-bit word and, when the load strobe rises, copies the upper 20 bits into one of four holding registers. The two lowest bits of the word select the register: the reference and feedback registers of a low-band channel and of a high-band channel. A downstream synthesizer reads the four registers as plain payloads. Their internal field layout is left generic, except for one tri-state bit and one power-down bit per channel.

From these two bits the block derives, for each channel, an enable and a charge-pump high-impedance control. A power-down request is either graceful or immediate. If the charge pump was already tri-stated when the request was loaded, the channel drops at once. Otherwise the pump is tri-stated first, and the channel drops on the next reference-divider boundary, which arrives as a tick input. The shared reference oscillator stays enabled while either channel runs. All three serial lines are sampled in the system clock domain.

Top module: `tri_wire_loader`

## Requirements
- R1: On each system clock edge that samples a rising serial clock, the data line is shifted into a 22-bit register, so the first bit sent ends up as word bit 21 (most significant first). The payload is word bits 21..2.
- R2: On the clock edge that first samples the load line high, the payload is written to the register selected by word bits 1..0. Code 0 selects the low-band reference, 1 the low-band feedback, 2 the high-band reference and 3 the high-band feedback. The other three registers keep their contents.
- R3: A written register shows its new value immediately after the clock edge that sampled the load rise. No register changes at any other time.
- R4: After reset all four registers read zero, both channels are enabled, both charge-pump high-impedance controls are low, and the oscillator enable is high.
- R5: Loading a feedback word whose power-down bit (payload bit 19) is 1, while that channel's tri-state bit (payload bit 19 of its reference register) is 0, raises the charge-pump high-impedance control at the load edge. The channel enable stays high until the first later edge that samples that channel's reference tick high, and it is low after that edge.
- R6: Loading a power-down bit of 1 while the channel's tri-state bit is already 1 clears the channel enable at the load edge itself.
- R7: Loading a feedback word with power-down bit 0 re-enables the channel at the load edge. The channel's charge-pump high-impedance control then equals its tri-state bit.
- R8: The oscillator enable is low only while both channels are disabled.
- R9: Serial shifting and register loads work unchanged while either or both channels are powered down.
- R10: While a channel runs, its charge-pump high-impedance control follows the tri-state bit of its reference register.
- R11: A reference tick of one channel has no effect on the other channel's pending power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdata | input | 1 | Serial data, most significant bit first |
| sload | input | 1 | Load strobe; a rise commits the word |
| if_ref_tick | input | 1 | Low-band reference-divider boundary pulse |
| rf_ref_tick | input | 1 | High-band reference-divider boundary pulse |
| if_ref_word | output | 20 | Low-band reference register payload |
| if_fb_word | output | 20 | Low-band feedback register payload |
| rf_ref_word | output | 20 | High-band reference register payload |
| rf_fb_word | output | 20 | High-band feedback register payload |
| if_enable | output | 1 | Low-band channel powered up |
| rf_enable | output | 1 | High-band channel powered up |
| if_cp_hiz | output | 1 | Low-band charge pump high impedance |
| rf_cp_hiz | output | 1 | High-band charge pump high impedance |
| osc_enable | output | 1 | Reference oscillator enable |

## Verification
Words with distinct payloads are sent to all four select codes, and every register is compared each cycle. This separates a wrong decode from a wrong bit order and from a write that leaks into a neighbouring register. Power-down is requested once with the tri-state bit clear and once with it set, so the graceful path and the immediate path are told apart. The graceful path also sees a tick on the wrong channel first, which shows whether the waiting channel listens only to its own divider. Loads made while a channel is down, followed by a power-up load, show that the port stays live and that the pump control returns to the tri-state bit.

// File: rtl/twl_pkg.sv
package twl_pkg;
    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_DRAIN = 2'd1,
        PWR_DOWN  = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/twl_shifter.sv
module twl_shifter #(
    parameter int WORD_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              sload,
    output logic [WORD_W-1:0] word,
    output logic              load_stb
);
    typedef struct packed {
        logic              sclk_prev;
        logic              sload_prev;
        logic [WORD_W-1:0] shreg;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d            = s_q;
        s_d.sclk_prev  = sclk;
        s_d.sload_prev = sload;
        if (sclk && !s_q.sclk_prev) begin
            s_d.shreg = {s_q.shreg[WORD_W-2:0], sdata};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word     = s_q.shreg;
    assign load_stb = sload && !s_q.sload_prev;
endmodule

// File: rtl/twl_latch_bank.sv
module twl_latch_bank #(
    parameter int WORD_W = 22,
    parameter int CODE_W = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     load_stb,
    input  logic [WORD_W-1:0]                        word,
    output logic [(1<<CODE_W)-1:0]                   wr,
    output logic [(1<<CODE_W)-1:0][WORD_W-CODE_W-1:0] regs
);
    localparam int PAY_W = WORD_W - CODE_W;
    localparam int NREG  = 1 << CODE_W;

    typedef struct packed {
        logic [NREG-1:0][PAY_W-1:0] r;
    } bank_t;

    bank_t b_d, b_q;

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign wr[g] = load_stb && (word[CODE_W-1:0] == CODE_W'(g));
    end

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr[i]) b_d.r[i] = word[WORD_W-1:CODE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign regs = b_q.r;
endmodule

// File: rtl/twl_chan_pwr.sv
module twl_chan_pwr
    import twl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fb_wr,
    input  logic pd_bit,
    input  logic ts_bit,
    input  logic ref_tick,
    output logic enable,
    output logic cp_hiz
);
    typedef struct packed {
        pwr_state_e st;
    } pwr_t;

    pwr_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (fb_wr) begin
            if (!pd_bit)                p_d.st = PWR_RUN;
            else if (p_q.st == PWR_RUN) p_d.st = ts_bit ? PWR_DOWN : PWR_DRAIN;
        end else if (p_q.st == PWR_DRAIN && ref_tick) begin
            p_d.st = PWR_DOWN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q.st <= PWR_RUN;
        else        p_q    <= p_d;
    end

    assign enable = (p_q.st != PWR_DOWN);
    assign cp_hiz = ts_bit || (p_q.st != PWR_RUN);
endmodule

// File: rtl/tri_wire_loader.sv
module tri_wire_loader #(
    parameter int WORD_W = 22,
    parameter int TS_POS = 19,
    parameter int PD_POS = 19
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                sdata,
    input  logic                sload,
    input  logic                if_ref_tick,
    input  logic                rf_ref_tick,
    output logic [WORD_W-3:0]   if_ref_word,
    output logic [WORD_W-3:0]   if_fb_word,
    output logic [WORD_W-3:0]   rf_ref_word,
    output logic [WORD_W-3:0]   rf_fb_word,
    output logic                if_enable,
    output logic                rf_enable,
    output logic                if_cp_hiz,
    output logic                rf_cp_hiz,
    output logic                osc_enable
);
    localparam int CODE_W = 2;
    localparam int PAY_W  = WORD_W - CODE_W;
    localparam int NREG   = 1 << CODE_W;
    localparam int NCH    = NREG / 2;

    logic [WORD_W-1:0]           word;
    logic                        load_stb;
    logic [NREG-1:0]             wr;
    logic [NREG-1:0][PAY_W-1:0]  regs;
    logic [NCH-1:0]              tick, en, hiz;

    twl_shifter #(.WORD_W(WORD_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sload(sload),
        .word(word), .load_stb(load_stb)
    );

    twl_latch_bank #(.WORD_W(WORD_W), .CODE_W(CODE_W)) i_bank (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .word(word),
        .wr(wr), .regs(regs)
    );

    assign tick = {rf_ref_tick, if_ref_tick};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        twl_chan_pwr i_pwr (
            .clk(clk), .rst_n(rst_n),
            .fb_wr(wr[2*c+1]),
            .pd_bit(word[CODE_W+PD_POS]),
            .ts_bit(regs[2*c][TS_POS]),
            .ref_tick(tick[c]),
            .enable(en[c]),
            .cp_hiz(hiz[c])
        );
    end

    assign if_ref_word = regs[0];
    assign if_fb_word  = regs[1];
    assign rf_ref_word = regs[2];
    assign rf_fb_word  = regs[3];
    assign if_enable   = en[0];
    assign rf_enable   = en[1];
    assign if_cp_hiz   = hiz[0];
    assign rf_cp_hiz   = hiz[1];
    assign osc_enable  = |en;
endmodule

// File: rtl/tri_wire_loader_chk.sv
module tri_wire_loader_chk #(
    parameter int PAY_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sload,
    input logic [PAY_W-1:0] if_ref_word,
    input logic [PAY_W-1:0] if_fb_word,
    input logic [PAY_W-1:0] rf_ref_word,
    input logic [PAY_W-1:0] rf_fb_word,
    input logic             if_enable,
    input logic             rf_enable,
    input logic             if_cp_hiz,
    input logic             rf_cp_hiz,
    input logic             osc_enable
);
    // R3
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(sload) || $past(sload, 2)) |->
        $stable({if_ref_word, if_fb_word, rf_ref_word, rf_fb_word}));

    // R5 and R6: a channel never drops while its pump was still driving
    if_drop_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(if_enable) |-> $past(if_cp_hiz));

    // R5 and R6
    rf_drop_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rf_enable) |-> $past(rf_cp_hiz));

    // R7
    if_wake_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(if_enable) |-> ($past(sload) && !$past(sload, 2)));

    // R7
    rf_wake_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_enable) |-> ($past(sload) && !$past(sload, 2)));

    // R8
    osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_enable) |-> ($fell(if_enable) || $fell(rf_enable)));
endmodule

bind tri_wire_loader tri_wire_loader_chk i_chk (.*);

// File: tb/test_tri_wire_loader.sv
module test_tri_wire_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
    logic if_tick = 1'b0, rf_tick = 1'b0;
    logic [19:0] if_ref_word, if_fb_word, rf_ref_word, rf_fb_word;
    logic if_enable, rf_enable, if_cp_hiz, rf_cp_hiz, osc_enable;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tri_wire_loader i_tri_wire_loader (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sload(sload),
        .if_ref_tick(if_tick), .rf_ref_tick(rf_tick),
        .if_ref_word(if_ref_word), .if_fb_word(if_fb_word),
        .rf_ref_word(rf_ref_word), .rf_fb_word(rf_fb_word),
        .if_enable(if_enable), .rf_enable(rf_enable),
        .if_cp_hiz(if_cp_hiz), .rf_cp_hiz(rf_cp_hiz), .osc_enable(osc_enable)
    );

    // behavioural reference model
    bit          m_bits[$];
    logic [19:0] m_lat[4];
    int          m_st[2];   // 0 running, 1 waiting for tick, 2 down
    bit          m_sclk_p, m_sload_p;
    bit          m_fbw[2];
    int          m_code;
    logic [19:0] m_pay;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bits = {};
            for (int i = 0; i < 22; i++) m_bits.push_back(1'b0);
            for (int i = 0; i < 4; i++) m_lat[i] = '0;
            m_st[0] = 0; m_st[1] = 0;
            m_sclk_p = 1'b0; m_sload_p = 1'b0;
        end else begin
            m_fbw[0] = 1'b0; m_fbw[1] = 1'b0;
            if (sload && !m_sload_p) begin
                m_code = 2 * int'(m_bits[20]) + int'(m_bits[21]);
                for (int j = 0; j < 20; j++) m_pay[j] = m_bits[19 - j];
                if (m_code % 2 == 1) begin
                    m_fbw[m_code / 2] = 1'b1;
                    if (!m_pay[19]) m_st[m_code / 2] = 0;
                    else if (m_st[m_code / 2] == 0)
                        m_st[m_code / 2] = m_lat[m_code - 1][19] ? 2 : 1;
                end
                m_lat[m_code] = m_pay;
            end
            if (!m_fbw[0] && m_st[0] == 1 && if_tick) m_st[0] = 2;
            if (!m_fbw[1] && m_st[1] == 1 && rf_tick) m_st[1] = 2;
            if (sclk && !m_sclk_p) begin
                m_bits.push_back(sdata);
                void'(m_bits.pop_front());
            end
            m_sclk_p  = sclk;
            m_sload_p = sload;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 if_ref", 32'(if_ref_word), 32'(m_lat[0]));
            check("R2 if_fb",  32'(if_fb_word),  32'(m_lat[1]));
            check("R2 rf_ref", 32'(rf_ref_word), 32'(m_lat[2]));
            check("R2 rf_fb",  32'(rf_fb_word),  32'(m_lat[3]));
            check("R5 if_enable", 32'(if_enable), 32'(m_st[0] != 2));
            check("R5 rf_enable", 32'(rf_enable), 32'(m_st[1] != 2));
            check("R10 if_cp_hiz", 32'(if_cp_hiz), 32'(m_lat[0][19] || m_st[0] != 0));
            check("R10 rf_cp_hiz", 32'(rf_cp_hiz), 32'(m_lat[2][19] || m_st[1] != 0));
            check("R8 osc", 32'(osc_enable), 32'(m_st[0] != 2 || m_st[1] != 2));
        end
    end

    // sends 22 bits MSB first; returns at the negedge after the load edge
    task automatic send_word(input logic [19:0] pay, input logic [1:0] code);
        logic [21:0] w;
        w = {pay, code};
        for (int i = 21; i >= 0; i--) begin
            @(negedge clk); sdata = w[i]; sclk = 1'b0;
            @(negedge clk); sclk = 1'b1;
        end
        @(negedge clk); sclk = 1'b0; sload = 1'b1;
        @(negedge clk); sload = 1'b0;
    endtask

    task automatic pulse_tick(input bit rf);
        @(negedge clk);
        if (rf) rf_tick = 1'b1; else if_tick = 1'b1;
        @(negedge clk);
        rf_tick = 1'b0; if_tick = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4 reset state
        check("R4 regs", 32'({if_ref_word, if_fb_word} | {rf_ref_word, rf_fb_word}), 32'd0);
        check("R4 enables", 32'({if_enable, rf_enable, osc_enable}), 32'b111);
        check("R4 cp_hiz", 32'({if_cp_hiz, rf_cp_hiz}), 32'b00);

        // R1 bit order, R3 update at load edge
        send_word(20'h12345, 2'd0);
        check("R1 msb first", 32'(if_ref_word), 32'h12345);
        check("R3 others untouched", 32'(if_fb_word), 32'h0);
        send_word(20'h0A5C3, 2'd1);
        check("R2 code 1", 32'(if_fb_word), 32'h0A5C3);
        check("R2 code 0 kept", 32'(if_ref_word), 32'h12345);
        send_word(20'h3C0F1, 2'd2);
        check("R2 code 2", 32'(rf_ref_word), 32'h3C0F1);
        send_word(20'h76543, 2'd3);
        check("R2 code 3", 32'(rf_fb_word), 32'h76543);

        // R5 graceful power-down of the low-band channel
        send_word(20'h80011, 2'd1);
        check("R5 pump hiz first", 32'(if_cp_hiz), 32'd1);
        check("R5 still enabled", 32'(if_enable), 32'd1);
        repeat (4) @(negedge clk);
        check("R5 waits for tick", 32'(if_enable), 32'd1);
        pulse_tick(1'b1);
        check("R11 other tick ignored", 32'(if_enable), 32'd1);
        pulse_tick(1'b0);
        check("R5 down after tick", 32'(if_enable), 32'd0);
        check("R8 osc on with one up", 32'(osc_enable), 32'd1);

        // R9 loads while down
        send_word(20'h0ABCD, 2'd0);
        check("R9 load while down", 32'(if_ref_word), 32'h0ABCD);
        check("R9 still down", 32'(if_enable), 32'd0);

        // R10 tri-state bit on running channel, then R6 immediate drop
        send_word(20'h80002, 2'd2);
        check("R10 ts bit hiz", 32'(rf_cp_hiz), 32'd1);
        check("R10 still enabled", 32'(rf_enable), 32'd1);
        send_word(20'h80003, 2'd3);
        check("R6 immediate down", 32'(rf_enable), 32'd0);
        check("R8 osc off both down", 32'(osc_enable), 32'd0);

        // R7 power-up
        send_word(20'h00044, 2'd1);
        check("R7 enable back", 32'(if_enable), 32'd1);
        check("R7 hiz follows ts", 32'(if_cp_hiz), 32'd0);
        check("R8 osc back", 32'(osc_enable), 32'd1);
        send_word(20'h00005, 2'd3);
        check("R7 rf enable back", 32'(rf_enable), 32'd1);
        check("R7 rf hiz follows ts", 32'(rf_cp_hiz), 32'd1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule